// File: doc/BRIEF.md
# Receiver Control Register Bank with Two-Wire Slave

This block holds the settings of a four-channel optical receiver front end and makes them reachable over a two-wire serial bus (I2C protocol, slave side only). It runs on the system clock and oversamples the bus lines. SCL and SDA each pass through a two-flop synchronizer. START and STOP are recognised from an SDA edge while SCL is high. The block pulls SDA low through an output-enable, so the pad is open-drain.

A write carries one register address and exactly one data byte. A read first writes the register address, then issues a repeated START with the direction bit set, and shifts out one byte. The bank holds one control byte and two setting bytes per channel. The control byte has a global power-down, a parallel-write mode that copies any channel write to all four channels, and a self-clearing clear bit.

A mode pin selects the source of the channel outputs. When the pin is low, the outputs come from shared pad-strap inputs and the serial port does not respond. When the pin is high, the outputs come only from the registers.

Top module: `rx_ctrl_i2c_bank`

## Requirements
- R1: The slave address is 7'b0001100, followed by a direction bit (0 write, 1 read); so the address byte is 8'h18 for a write and 8'h19 for a read. A matching byte is acknowledged by holding SDA low through the high phase of the ninth clock. A non-matching address leaves SDA released (the bench reads 1), and the rest of that transaction is ignored.
- R2: A write is START, 8'h18, register address, data byte, STOP. Each byte is acknowledged. Channel n (0..3) has a setting byte A at address 1+6n (01h, 07h, 0Dh, 13h), holding rate in bits 7:4 and amplitude in bits 3:0. It has a setting byte B at address 2+6n (02h, 08h, 0Eh, 14h), holding power-down in bit 7, output-disable in bit 6, gain in bits 5:4 and threshold in bits 3:0. The outputs pack channel n at ch_amp/ch_rate/ch_th[4n+:4], ch_gain[2n+:2], ch_pd[n] and ch_dis[n].
- R3: The slave changes its SDA drive only while SCL is low.
- R4: A read writes the register address, issues a repeated START, sends 8'h19, and then receives one byte, MSB first, after which the master NACKs. The byte equals the register content. The control byte at address 00h reads as {0, global_pd, 5'b0, parallel_write}.
- R5: Only one data byte is taken per transaction. A further byte before STOP is not acknowledged and is discarded.
- R6: A write to a reserved address (any address other than 00h and the eight channel bytes) is acknowledged, changes no output, and the location reads 00h.
- R7: With parallel write set (bit 0 of 00h), a write to any channel byte A updates byte A of all four channels, and a write to any byte B updates byte B of all four channels.
- R8: Writing 00h with bit 7 set clears every register to zero. Bit 7 itself is never stored and reads as 0.
- R9: A channel's ch_pd is high when either its own power-down bit or the global power-down bit (bit 6 of 00h) is set.
- R10: With serial_en low, every channel output comes from the pad inputs, and ch_pd and ch_dis are 0. The slave does not acknowledge its address, and register contents are unchanged.
- R11: After reset, with serial_en high, all channel outputs are zero and sda_oe is low.
- R12: A repeated START at any point restarts address matching. A write cut short before its data byte changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| serial_en | input | 1 | High: register-driven outputs and active slave; low: pad-driven outputs |
| pad_amp | input | 4 | Shared amplitude strap for pad mode |
| pad_rate | input | 4 | Shared rate strap for pad mode |
| pad_gain | input | 2 | Shared gain strap for pad mode |
| pad_th | input | 4 | Shared threshold strap for pad mode |
| ch_amp | output | 16 | Amplitude per channel, 4 bits each |
| ch_rate | output | 16 | Rate per channel, 4 bits each |
| ch_gain | output | 8 | Gain per channel, 2 bits each |
| ch_th | output | 16 | Threshold per channel, 4 bits each |
| ch_pd | output | 4 | Power-down per channel |
| ch_dis | output | 4 | Output-buffer disable per channel |

## Verification
The bench sends a second data byte after a complete write. A slave that kept accepting bytes would acknowledge it and overwrite the register. It cuts a write short with a repeated START just after the register address. A design that failed to restart matching, or that committed the partial write, would leave channel 4 changed. It checks the parallel-write copy and the clear bit, whose faults show as only one channel updated or as stale settings surviving the clear. It also writes while the mode pin is low, which a design that did not gate the slave would acknowledge and store.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam logic [6:0] RXC_DEV_ADDR  = 7'b0001100;
    localparam int         RXC_CH_BASE   = 1;
    localparam int         RXC_CH_STRIDE = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_REG,
        ST_ACK_REG,
        ST_DATA,
        ST_ACK_DATA,
        ST_READ,
        ST_RACK,
        ST_IGNORE
    } bus_st_e;
endpackage

// File: rtl/rxc_busync.sv
module rxc_busync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d     = q;
        d.scl = {q.scl[1:0], scl_in};
        d.sda = {q.sda[1:0], sda_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl[1];
    assign sda_s     = q.sda[1];
    assign scl_rise  = q.scl[1] & ~q.scl[2];
    assign scl_fall  = ~q.scl[1] & q.scl[2];
    assign bus_start = q.scl[1] & q.scl[2] & q.sda[2] & ~q.sda[1];
    assign bus_stop  = q.scl[1] & q.scl[2] & ~q.sda[2] & q.sda[1];
endmodule

// File: rtl/rxc_i2c_slave.sv
module rxc_i2c_slave
    import rxc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = RXC_DEV_ADDR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    typedef struct packed {
        bus_st_e    st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic       rw;
        logic [7:0] ptr;
        logic       oe;
        logic       wr;
    } slv_t;

    slv_t q, d;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (!en) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (bus_start) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_REG, ST_DATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.rw = q.sh[0];
                                d.oe = 1'b1;
                                d.st = ST_ACK_ADDR;
                            end else begin
                                d.st = ST_IGNORE;
                            end
                        end else if (q.st == ST_REG) begin
                            d.ptr = q.sh;
                            d.oe  = 1'b1;
                            d.st  = ST_ACK_REG;
                        end else begin
                            d.wr = 1'b1;
                            d.oe = 1'b1;
                            d.st = ST_ACK_DATA;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_READ;
                            d.tx = rd_data;
                            d.oe = ~rd_data[7];
                        end else begin
                            d.st = ST_REG;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_ACK_REG: begin
                    if (scl_fall) begin
                        d.st  = ST_DATA;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end
                end
                ST_ACK_DATA: begin
                    if (scl_fall) begin
                        d.st = ST_IGNORE;
                        d.oe = 1'b0;
                    end
                end
                ST_READ: begin
                    if (scl_rise) d.cnt = q.cnt + 4'd1;
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b1};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) d.st = ST_IGNORE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign ptr     = q.ptr;
    assign wr_en   = q.wr;
    assign wr_data = q.sh;

    // R3: drive changes land only in the SCL low phase
    assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(bus_start) && !$past(bus_stop) && (q.oe != $past(q.oe)))
        |-> !scl_s);

    // R10: a disabled slave neither drives nor writes
    assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sda_oe && !wr_en));
endmodule

// File: rtl/rxc_regbank.sv
module rxc_regbank
    import rxc_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CH_BASE   = RXC_CH_BASE,
    parameter int CH_STRIDE = RXC_CH_STRIDE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       rd_addr,
    output logic [7:0]       rd_data,
    output logic [NCH*8-1:0] ar_o,
    output logic [NCH*8-1:0] tg_o,
    output logic             gpd_o
);
    typedef struct packed {
        logic                gpd;
        logic                pw;
        logic [NCH-1:0][7:0] ar;
        logic [NCH-1:0][7:0] tg;
    } bank_t;

    bank_t q, d;
    logic  hit_ar, hit_tg;

    function automatic logic [7:0] addr_a(input int k);
        return 8'(CH_BASE + CH_STRIDE * k);
    endfunction

    function automatic logic [7:0] addr_b(input int k);
        return 8'(CH_BASE + CH_STRIDE * k + 1);
    endfunction

    always_comb begin
        d      = q;
        hit_ar = 1'b0;
        hit_tg = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            if (wr_addr == addr_a(k)) hit_ar = 1'b1;
            if (wr_addr == addr_b(k)) hit_tg = 1'b1;
        end
        if (wr_en) begin
            if (wr_addr == 8'h00) begin
                if (wr_data[7]) begin
                    d = '0;
                end else begin
                    d.gpd = wr_data[6];
                    d.pw  = wr_data[0];
                end
            end
            for (int k = 0; k < NCH; k++) begin
                if (hit_ar && (q.pw || wr_addr == addr_a(k))) d.ar[k] = wr_data;
                if (hit_tg && (q.pw || wr_addr == addr_b(k))) d.tg[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == 8'h00) rd_data = {1'b0, q.gpd, 5'b0, q.pw};
        for (int k = 0; k < NCH; k++) begin
            if (rd_addr == addr_a(k)) rd_data = q.ar[k];
            if (rd_addr == addr_b(k)) rd_data = q.tg[k];
        end
    end

    assign ar_o  = q.ar;
    assign tg_o  = q.tg;
    assign gpd_o = q.gpd;

    // R8: the clear bit leaves the whole bank at zero
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'h00 && wr_data[7]) |=> (ar_o == '0 && tg_o == '0 && !gpd_o));

    // R6: a reserved write touches nothing
    assert_reserved_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 8'h00 && !hit_ar && !hit_tg)
        |=> ($stable(ar_o) && $stable(tg_o) && $stable(gpd_o)));

    // R7: broadcast lands in every channel
    assert_broadcast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.pw && hit_ar) |=> (ar_o == {NCH{$past(wr_data)}}));
endmodule

// File: rtl/rx_ctrl_i2c_bank.sv
module rx_ctrl_i2c_bank
    import rxc_pkg::*;
#(
    parameter int         NCH      = 4,
    parameter logic [6:0] DEV_ADDR = RXC_DEV_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic             serial_en,
    input  logic [3:0]       pad_amp,
    input  logic [3:0]       pad_rate,
    input  logic [1:0]       pad_gain,
    input  logic [3:0]       pad_th,
    output logic [NCH*4-1:0] ch_amp,
    output logic [NCH*4-1:0] ch_rate,
    output logic [NCH*2-1:0] ch_gain,
    output logic [NCH*4-1:0] ch_th,
    output logic [NCH-1:0]   ch_pd,
    output logic [NCH-1:0]   ch_dis
);
    logic       scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0] ptr, wr_data, rd_data;
    logic       wr_en, gpd;
    logic [NCH*8-1:0] ar, tg;

    rxc_busync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    rxc_i2c_slave #(.DEV_ADDR(DEV_ADDR)) u_slave (
        .clk(clk), .rst_n(rst_n), .en(serial_en),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop), .rd_data(rd_data),
        .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data)
    );

    rxc_regbank #(.NCH(NCH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
        .rd_addr(ptr), .rd_data(rd_data), .ar_o(ar), .tg_o(tg), .gpd_o(gpd)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign ch_amp[4*k +: 4]  = serial_en ? ar[8*k +: 4]     : pad_amp;
        assign ch_rate[4*k +: 4] = serial_en ? ar[8*k + 4 +: 4] : pad_rate;
        assign ch_th[4*k +: 4]   = serial_en ? tg[8*k +: 4]     : pad_th;
        assign ch_gain[2*k +: 2] = serial_en ? tg[8*k + 4 +: 2] : pad_gain;
        assign ch_pd[k]          = serial_en & (tg[8*k + 7] | gpd);
        assign ch_dis[k]         = serial_en & tg[8*k + 6];
    end
endmodule

// File: tb/rx_ctrl_i2c_bank_test.sv
module rx_ctrl_i2c_bank_test;
    localparam int CLK_P = 10;
    localparam int Q     = 8;

    logic clk = 0, rst_n = 0;
    logic scl_m = 1, sda_m = 1;
    logic serial_en = 1;
    logic [3:0] pad_amp = 0, pad_rate = 0, pad_th = 0;
    logic [1:0] pad_gain = 0;
    logic sda_oe, sda_line;
    logic [15:0] ch_amp, ch_rate, ch_th;
    logic [7:0]  ch_gain;
    logic [3:0]  ch_pd, ch_dis;

    int errors = 0, checks = 0, r3_viol = 0;
    string sb_tag[$];
    int    sb_exp[$];
    int    sb_obs[$];

    assign sda_line = sda_m & ~sda_oe;

    rx_ctrl_i2c_bank uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .serial_en(serial_en), .pad_amp(pad_amp), .pad_rate(pad_rate),
        .pad_gain(pad_gain), .pad_th(pad_th), .ch_amp(ch_amp), .ch_rate(ch_rate),
        .ch_gain(ch_gain), .ch_th(ch_th), .ch_pd(ch_pd), .ch_dis(ch_dis)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares observed bus results with queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (sb_obs.size() > 0) begin
                chk(sb_tag.pop_front(), sb_obs.pop_front(), sb_exp.pop_front());
            end
        end
    end

    // R3 observer: drive must not change while SCL is high
    logic oe_prev = 0;
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_m) r3_viol++;
        oe_prev <= sda_oe;
    end

    task automatic hold(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; hold(); scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 0; hold(); scl_m = 1; hold(); sda_m = 1; hold();
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; hold(); scl_m = 1; hold(); s = sda_line; hold(); scl_m = 0; hold();
    endtask

    task automatic send_byte(logic [7:0] v, string tag, int exp_ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(v[i], s);
        bit_io(1'b1, s);
        sb_tag.push_back(tag); sb_exp.push_back(exp_ack); sb_obs.push_back(int'(s));
    endtask

    task automatic recv_byte(string tag, int exp);
        logic s;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            v[i] = s;
        end
        bit_io(1'b1, s);
        sb_tag.push_back(tag); sb_exp.push_back(exp); sb_obs.push_back(int'(v));
    endtask

    task automatic wr_reg(logic [7:0] ra, logic [7:0] dv, string tag);
        bus_start();
        send_byte(8'h18, {tag, " addr ack"}, 0);
        send_byte(ra, {tag, " reg ack"}, 0);
        send_byte(dv, {tag, " data ack"}, 0);
        bus_stop();
    endtask

    task automatic rd_reg(logic [7:0] ra, int exp, string tag);
        bus_start();
        send_byte(8'h18, {tag, " addr ack"}, 0);
        send_byte(ra, {tag, " reg ack"}, 0);
        bus_start();
        send_byte(8'h19, {tag, " read addr ack"}, 0);
        recv_byte({tag, " read data"}, exp);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 sda_oe", sda_oe, 0);
        chk("R11 ch_amp", ch_amp, 0);
        chk("R11 ch_th", ch_th, 0);
        chk("R11 ch_pd", ch_pd, 0);

        // R1 R2 basic write of channel 1 byte A
        wr_reg(8'h01, 8'hA5, "R1 R2 wr01");
        chk("R2 ch_amp", ch_amp, 16'h0005);
        chk("R2 ch_rate", ch_rate, 16'h000A);
        // R2 channel 3 byte B
        wr_reg(8'h0E, 8'hE9, "R2 wr0E");
        chk("R2 ch_pd", ch_pd, 4'b0100);
        chk("R2 ch_dis", ch_dis, 4'b0100);
        chk("R2 ch_gain", ch_gain, 8'h20);
        chk("R2 ch_th", ch_th, 16'h0900);
        // R4 reads
        rd_reg(8'h0E, 8'hE9, "R4 rd0E");
        rd_reg(8'h01, 8'hA5, "R4 rd01");

        // R1 mismatched address
        bus_start();
        send_byte(8'h1A, "R1 wrong addr nack", 1);
        send_byte(8'h01, "R1 ignored reg byte", 1);
        bus_stop();
        chk("R1 ch_amp unchanged", ch_amp, 16'h0005);

        // R6 reserved address
        wr_reg(8'h05, 8'hFF, "R6 wr05");
        chk("R6 ch_amp", ch_amp, 16'h0005);
        chk("R6 ch_th", ch_th, 16'h0900);
        chk("R6 ch_pd", ch_pd, 4'b0100);
        rd_reg(8'h05, 0, "R6 rd05");

        // R5 one data byte only
        bus_start();
        send_byte(8'h18, "R5 addr ack", 0);
        send_byte(8'h07, "R5 reg ack", 0);
        send_byte(8'h33, "R5 data ack", 0);
        send_byte(8'h44, "R5 extra byte nack", 1);
        bus_stop();
        chk("R5 ch_amp", ch_amp, 16'h0035);
        chk("R5 ch_rate", ch_rate, 16'h003A);
        rd_reg(8'h07, 8'h33, "R5 rd07");

        // R12 repeated start cuts a write short
        bus_start();
        send_byte(8'h18, "R12 addr ack", 0);
        send_byte(8'h13, "R12 reg ack", 0);
        bus_start();
        send_byte(8'h18, "R12 re-addr ack", 0);
        send_byte(8'h14, "R12 reg2 ack", 0);
        send_byte(8'h05, "R12 data ack", 0);
        bus_stop();
        chk("R12 ch_th", ch_th, 16'h5900);
        chk("R12 ch_amp untouched", ch_amp, 16'h0035);

        // R9 global power-down
        wr_reg(8'h00, 8'h40, "R9 wr00");
        chk("R9 ch_pd", ch_pd, 4'b1111);
        rd_reg(8'h00, 8'h40, "R4 R9 rd00");

        // R7 broadcast
        wr_reg(8'h00, 8'h41, "R7 wr00");
        wr_reg(8'h02, 8'h23, "R7 wr02");
        chk("R7 ch_gain", ch_gain, 8'hAA);
        chk("R7 ch_th", ch_th, 16'h3333);
        chk("R7 ch_dis", ch_dis, 0);
        chk("R7 R9 ch_pd", ch_pd, 4'b1111);
        wr_reg(8'h0D, 8'h7C, "R7 wr0D");
        chk("R7 ch_amp", ch_amp, 16'hCCCC);
        chk("R7 ch_rate", ch_rate, 16'h7777);
        rd_reg(8'h13, 8'h7C, "R7 rd13");
        rd_reg(8'h00, 8'h41, "R4 rd00 pw");

        // R8 clear bit
        wr_reg(8'h00, 8'h80, "R8 wr00");
        chk("R8 ch_amp", ch_amp, 0);
        chk("R8 ch_rate", ch_rate, 0);
        chk("R8 ch_gain", ch_gain, 0);
        chk("R8 ch_th", ch_th, 0);
        chk("R8 ch_pd", ch_pd, 0);
        rd_reg(8'h00, 0, "R8 rd00");

        // R10 pad mode
        serial_en = 0;
        pad_amp = 4'h9; pad_rate = 4'hF; pad_gain = 2'h3; pad_th = 4'h6;
        repeat (4) @(negedge clk);
        chk("R10 ch_amp", ch_amp, 16'h9999);
        chk("R10 ch_rate", ch_rate, 16'hFFFF);
        chk("R10 ch_gain", ch_gain, 8'hFF);
        chk("R10 ch_th", ch_th, 16'h6666);
        chk("R10 ch_pd", ch_pd, 0);
        chk("R10 ch_dis", ch_dis, 0);
        bus_start();
        send_byte(8'h18, "R10 no ack when off", 1);
        send_byte(8'h01, "R10 reg ignored", 1);
        send_byte(8'hFF, "R10 data ignored", 1);
        bus_stop();
        serial_en = 1;
        repeat (4) @(negedge clk);
        chk("R10 ch_amp after", ch_amp, 0);
        rd_reg(8'h01, 0, "R10 rd01");

        repeat (4) @(negedge clk);
        chk("R3 drive changes during SCL high", r3_viol, 0);
        while (sb_obs.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule